// File: doc/BRIEF.md
# Monitor Limit Comparator

This block watches a stream of digitised monitor readings for an optical transceiver controller and raises alarm and warning status flags. There are five monitored quantities: die temperature, supply voltage, laser bias current, transmitted optical power and received optical power. Each reading arrives as a one-cycle strobe that carries a channel number and a 16-bit value. The block compares the reading against the four limits held for that channel: a high alarm, a low alarm, a high warning and a low warning.

Each channel owns two alarm flags and two warning flags. Each class of flag is either transparent, following the latest reading, or latched, holding once set. An enable mask per class decides which flags feed a registered, active-high transmit-fault output. Limits, enables, latch configuration and flag clears all arrive through a simple register write port.

A small two-state machine tracks the transmit-disable input. Its states are `TXS_ACTIVE` (transmitter enabled) and `TXS_DISABLED`. The transition `T_DISABLE` (ACTIVE to DISABLED, taken when the input is high) emits a one-cycle clear pulse. The transition `T_ENABLE` (DISABLED to ACTIVE, taken when the input is low) emits nothing. Reset enters `TXS_ACTIVE`.

Top module: `mon_limit_cmp`

## Requirements
- R1: A write to address 4*ch+k stores a 16-bit limit for channel ch (0 temperature, 1 supply, 2 bias, 3 transmit power, 4 receive power), where k=0 is the high alarm, k=1 the low alarm, k=2 the high warning and k=3 the low warning. Address 20 holds the alarm enable mask, 21 the warning enable mask, and 22 the configuration (bit 0 latches alarms, bit 1 latches warnings).
- R2: A high flag is set when the reading is equal to or above its high limit. Flag bit 2*ch is the high flag of channel ch in both alarm_flags and warn_flags.
- R3: A low flag is set when the reading is equal to or below its low limit. Flag bit 2*ch+1 is the low flag of channel ch.
- R4: Channel 0 compares the reading and its limits as two's-complement signed values. Channels 1 to 4 compare as unsigned values.
- R5: Flags change on the clock edge that samples meas_valid, and only for the channel named by meas_ch. The flags of other channels are unchanged. A channel number of 5 or above changes no flag.
- R6: In transparent mode a flag takes the result of the latest reading for its channel, so it drops once the reading returns inside the limit.
- R7: In latched mode a set flag stays set until it is cleared. A write to address 23 (alarms) or 24 (warnings) clears, on that edge, each flag whose bit in wr_data is 1. This clear applies in both modes.
- R8: A rising edge of tx_disable clears the latched alarm and warning flags of channels 2 and 3 on the next edge. It leaves the flags of channels 0, 1 and 4 untouched. Holding tx_disable high clears nothing further. Transparent flags are not cleared.
- R9: tx_fault is high one cycle after any flag whose enable bit is 1 is high, and low one cycle after no enabled flag is high.
- R10: After reset all flags, tx_fault, limits, enables and configuration are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_valid | input | 1 | One-cycle strobe for a new reading |
| meas_ch | input | 3 | Channel number of the reading |
| meas_value | input | 16 | Reading value |
| tx_disable | input | 1 | Transmit-disable level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| alarm_flags | output | 10 | Alarm flags, high/low pair per channel |
| warn_flags | output | 10 | Warning flags, high/low pair per channel |
| tx_fault | output | 1 | Registered OR of enabled flags |

## Verification
The bench sweeps every channel across its four limits in steps of 5, landing exactly on each limit. A comparator that used strict inequality would therefore miss the equality points. The temperature sweep crosses zero with negative limits, so an unsigned temperature compare would raise high flags on every negative reading. Each sweep is repeated in latched mode, where a flag that dropped on a descending reading would be caught. The transmit-disable tests check three things: that receive-power and temperature flags survive the clear, that a held level does not clear flags set afterwards, and that transparent flags are untouched.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
    typedef enum logic {
        TXS_ACTIVE   = 1'b0,
        TXS_DISABLED = 1'b1
    } txs_e;

    // Index of each comparison result inside a channel's hit vector
    localparam int HIT_AH = 0;
    localparam int HIT_AL = 1;
    localparam int HIT_WH = 2;
    localparam int HIT_WL = 3;
    localparam int CH_TEMP = 0;
endpackage

// File: rtl/mlc_regs.sv
module mlc_regs #(
    parameter int W   = 16,
    parameter int NCH = 5,
    parameter int AW  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [W-1:0]              wr_data,
    output logic [NCH*4-1:0][W-1:0]   lim,
    output logic [2*NCH-1:0]          aen,
    output logic [2*NCH-1:0]          wen,
    output logic                      lat_a,
    output logic                      lat_w,
    output logic [2*NCH-1:0]          clr_a,
    output logic [2*NCH-1:0]          clr_w
);
    localparam int NF     = 2 * NCH;
    localparam int NL     = 4 * NCH;
    localparam int A_AEN  = NL;
    localparam int A_WEN  = NL + 1;
    localparam int A_CFG  = NL + 2;
    localparam int A_CLRA = NL + 3;
    localparam int A_CLRW = NL + 4;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim   <= '0;
            aen   <= '0;
            wen   <= '0;
            lat_a <= 1'b0;
            lat_w <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < NL; i++)
                if (int'(wr_addr) == i) lim[i] <= wr_data;
            if (int'(wr_addr) == A_AEN) aen <= wr_data[NF-1:0];
            if (int'(wr_addr) == A_WEN) wen <= wr_data[NF-1:0];
            if (int'(wr_addr) == A_CFG) begin
                lat_a <= wr_data[0];
                lat_w <= wr_data[1];
            end
        end
    end

    always_comb begin
        clr_a = (wr_en && int'(wr_addr) == A_CLRA) ? wr_data[NF-1:0] : '0;
        clr_w = (wr_en && int'(wr_addr) == A_CLRW) ? wr_data[NF-1:0] : '0;
    end
endmodule

// File: rtl/mlc_cmp.sv
module mlc_cmp #(
    parameter int W         = 16,
    parameter bit IS_SIGNED = 1'b0
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] lim_ah,
    input  logic [W-1:0] lim_al,
    input  logic [W-1:0] lim_wh,
    input  logic [W-1:0] lim_wl,
    output logic [3:0]   hits
);
    generate
        if (IS_SIGNED) begin : g_signed
            assign hits = {$signed(val) <= $signed(lim_wl),
                           $signed(val) >= $signed(lim_wh),
                           $signed(val) <= $signed(lim_al),
                           $signed(val) >= $signed(lim_ah)};
        end else begin : g_unsigned
            assign hits = {val <= lim_wl, val >= lim_wh,
                           val <= lim_al, val >= lim_ah};
        end
    endgenerate
endmodule

// File: rtl/mlc_txdis.sv
module mlc_txdis
    import mlc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_disable,
    output logic clr_tx
);
    txs_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXS_ACTIVE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        clr_tx   = 1'b0;
        unique case (state)
            TXS_ACTIVE: if (tx_disable) begin       // T_DISABLE
                state_nx = TXS_DISABLED;
                clr_tx   = 1'b1;
            end
            TXS_DISABLED: if (!tx_disable)          // T_ENABLE
                state_nx = TXS_ACTIVE;
            default: state_nx = TXS_ACTIVE;
        endcase
    end

    // R8: a held disable level never produces a second clear
    p_one_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_tx |=> !clr_tx);
endmodule

// File: rtl/mlc_flags.sv
module mlc_flags #(
    parameter int             NCH   = 5,
    parameter int             CHW   = 3,
    parameter logic [NCH-1:0] TX_CH = 5'b01100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               meas_valid,
    input  logic [CHW-1:0]     meas_ch,
    input  logic [3:0]         hits,
    input  logic [2*NCH-1:0]   clr_a,
    input  logic [2*NCH-1:0]   clr_w,
    input  logic               clr_tx,
    input  logic               lat_a,
    input  logic               lat_w,
    input  logic [2*NCH-1:0]   aen,
    input  logic [2*NCH-1:0]   wen,
    output logic [2*NCH-1:0]   alarm_flags,
    output logic [2*NCH-1:0]   warn_flags,
    output logic               fault
);
    import mlc_pkg::*;
    localparam int NF = 2 * NCH;

    logic [NF-1:0] upd, new_a, new_w, txm, keep_a, keep_w, nxt_a, nxt_w;

    always_comb begin
        upd   = '0;
        new_a = '0;
        new_w = '0;
        txm   = '0;
        for (int c = 0; c < NCH; c++) begin
            if (meas_valid && int'(meas_ch) == c) begin
                upd[2*c +: 2] = 2'b11;
                new_a[2*c]    = hits[HIT_AH];
                new_a[2*c+1]  = hits[HIT_AL];
                new_w[2*c]    = hits[HIT_WH];
                new_w[2*c+1]  = hits[HIT_WL];
            end
            txm[2*c +: 2] = {2{TX_CH[c] & clr_tx}};
        end
        keep_a = alarm_flags & ~clr_a & ~(lat_a ? txm : '0);
        keep_w = warn_flags  & ~clr_w & ~(lat_w ? txm : '0);
        nxt_a  = lat_a ? (keep_a | (new_a & upd)) : ((keep_a & ~upd) | (new_a & upd));
        nxt_w  = lat_w ? (keep_w | (new_w & upd)) : ((keep_w & ~upd) | (new_w & upd));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_flags <= '0;
            warn_flags  <= '0;
            fault       <= 1'b0;
        end else begin
            alarm_flags <= nxt_a;
            warn_flags  <= nxt_w;
            fault       <= |((alarm_flags & aen) | (warn_flags & wen));
        end
    end

    // R5: with no reading and no clear the flags do not move
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_valid && clr_a == '0 && !clr_tx) |=> $stable(alarm_flags));
    // R7: latched alarm flags never drop without a clear
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_a && clr_a == '0 && !clr_tx) |=>
        ((alarm_flags & $past(alarm_flags)) == $past(alarm_flags)));
    // R8: the disable edge empties latched transmit-side alarms
    p_tx_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tx && lat_a && !meas_valid) |=> ((alarm_flags & $past(txm)) == '0));
    // R8: channels outside the transmit set survive the disable edge
    p_rx_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tx && !meas_valid && clr_a == '0) |=>
        ((alarm_flags & ~$past(txm)) == ($past(alarm_flags) & ~$past(txm))));
    // R9: with both masks empty the fault stays low
    p_fault_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (aen == '0 && wen == '0) |=> !fault);
endmodule

// File: rtl/mon_limit_cmp.sv
module mon_limit_cmp #(
    parameter int             W      = 16,
    parameter int             NCH    = 5,
    parameter int             CHW    = 3,
    parameter int             ADDR_W = 5,
    parameter logic [NCH-1:0] TX_CH  = 5'b01100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                meas_valid,
    input  logic [CHW-1:0]      meas_ch,
    input  logic [W-1:0]        meas_value,
    input  logic                tx_disable,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [W-1:0]        wr_data,
    output logic [2*NCH-1:0]    alarm_flags,
    output logic [2*NCH-1:0]    warn_flags,
    output logic                tx_fault
);
    import mlc_pkg::*;
    localparam int NF = 2 * NCH;

    logic [NCH*4-1:0][W-1:0] lim;
    logic [NF-1:0]           aen, wen, clr_a, clr_w;
    logic                    lat_a, lat_w, clr_tx;
    logic [NCH-1:0][3:0]     hits;
    logic [3:0]              sel_hits;

    mlc_regs #(.W(W), .NCH(NCH), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lim(lim), .aen(aen), .wen(wen),
        .lat_a(lat_a), .lat_w(lat_w), .clr_a(clr_a), .clr_w(clr_w));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        mlc_cmp #(.W(W), .IS_SIGNED(c == CH_TEMP)) u_cmp (
            .val(meas_value),
            .lim_ah(lim[4*c+0]), .lim_al(lim[4*c+1]),
            .lim_wh(lim[4*c+2]), .lim_wl(lim[4*c+3]),
            .hits(hits[c]));
    end

    always_comb begin
        sel_hits = '0;
        for (int c = 0; c < NCH; c++)
            if (int'(meas_ch) == c) sel_hits = hits[c];
    end

    mlc_txdis u_txdis (
        .clk(clk), .rst_n(rst_n), .tx_disable(tx_disable), .clr_tx(clr_tx));

    mlc_flags #(.NCH(NCH), .CHW(CHW), .TX_CH(TX_CH)) u_flags (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_ch(meas_ch),
        .hits(sel_hits), .clr_a(clr_a), .clr_w(clr_w), .clr_tx(clr_tx),
        .lat_a(lat_a), .lat_w(lat_w), .aen(aen), .wen(wen),
        .alarm_flags(alarm_flags), .warn_flags(warn_flags), .fault(tx_fault));

    // R5: an out-of-range channel number leaves every flag alone
    p_bad_ch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && int'(meas_ch) >= NCH && clr_a == '0 && !clr_tx)
        |=> $stable(alarm_flags));
endmodule

// File: tb/mon_limit_cmp_tb_top.sv
`timescale 1ns/1ps
module mon_limit_cmp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_valid = 1'b0;
    logic [2:0]  meas_ch = '0;
    logic [15:0] meas_value = '0;
    logic        tx_disable = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [9:0]  alarm_flags, warn_flags;
    logic        tx_fault;

    int checks = 0;
    int errors = 0;

    logic [15:0] lim_m [5][4];
    logic [9:0]  exp_a = '0, exp_w = '0, aen_m = '0, wen_m = '0;
    logic        lat_a_m = 1'b0, lat_w_m = 1'b0;
    int          base_m [5];

    always #2 clk = ~clk;

    mon_limit_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_ch(meas_ch),
        .meas_value(meas_value), .tx_disable(tx_disable), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .alarm_flags(alarm_flags),
        .warn_flags(warn_flags), .tx_fault(tx_fault));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int addr, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr[4:0]; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [3:0] ref_hits(input int ch, input logic [15:0] v);
        logic [3:0] h;
        if (ch == 0) begin
            h[0] = $signed(v) >= $signed(lim_m[ch][0]);
            h[1] = $signed(v) <= $signed(lim_m[ch][1]);
            h[2] = $signed(v) >= $signed(lim_m[ch][2]);
            h[3] = $signed(v) <= $signed(lim_m[ch][3]);
        end else begin
            h[0] = v >= lim_m[ch][0];
            h[1] = v <= lim_m[ch][1];
            h[2] = v >= lim_m[ch][2];
            h[3] = v <= lim_m[ch][3];
        end
        return h;
    endfunction

    function automatic logic exp_fault();
        return |((exp_a & aen_m) | (exp_w & wen_m));
    endfunction

    task automatic meas(input string req, input int ch, input logic [15:0] v);
        logic [3:0] h;
        @(negedge clk);
        meas_valid = 1'b1; meas_ch = ch[2:0]; meas_value = v;
        if (ch < 5) begin
            h = ref_hits(ch, v);
            if (lat_a_m) begin
                exp_a[2*ch] |= h[0]; exp_a[2*ch+1] |= h[1];
            end else begin
                exp_a[2*ch] = h[0]; exp_a[2*ch+1] = h[1];
            end
            if (lat_w_m) begin
                exp_w[2*ch] |= h[2]; exp_w[2*ch+1] |= h[3];
            end else begin
                exp_w[2*ch] = h[2]; exp_w[2*ch+1] = h[3];
            end
        end
        @(negedge clk);
        meas_valid = 1'b0;
        chk({req, " alarm"}, {6'd0, alarm_flags}, {6'd0, exp_a});
        chk({req, " warn"},  {6'd0, warn_flags},  {6'd0, exp_w});
        @(negedge clk);
        chk("R9 fault", {15'd0, tx_fault}, {15'd0, exp_fault()});
    endtask

    task automatic sweep(input string req, input int ch, input bit down);
        for (int i = 0; i <= 24; i++) begin
            int off;
            off = down ? (60 - 5 * i) : (-60 + 5 * i);
            meas(req, ch, 16'(base_m[ch] + off));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 alarm reset", {6'd0, alarm_flags}, 16'd0);
        chk("R10 warn reset",  {6'd0, warn_flags},  16'd0);
        chk("R10 fault reset", {15'd0, tx_fault},   16'd0);
        // R10: limits reset to zero, so an unsigned zero reading hits both low and high
        meas("R10 R2 R3 zero limits", 1, 16'd0);

        // R1: program limits per channel
        for (int c = 0; c < 5; c++) begin
            base_m[c] = (c == 0) ? -10 : 20000 + 9000 * c;
            lim_m[c][0] = 16'(base_m[c] + 40);
            lim_m[c][1] = 16'(base_m[c] - 40);
            lim_m[c][2] = 16'(base_m[c] + 20);
            lim_m[c][3] = 16'(base_m[c] - 20);
            for (int k = 0; k < 4; k++) wr(4 * c + k, lim_m[c][k]);
        end
        aen_m = 10'b0101010101; wen_m = 10'b1010101010;
        wr(20, {6'd0, aen_m});
        wr(21, {6'd0, wen_m});

        // R2 R3 R4 R6: transparent sweeps up and down across every limit
        for (int c = 0; c < 5; c++) begin
            sweep("R1 R2 R3 R4 R6 up", c, 1'b0);
            sweep("R6 down", c, 1'b1);
        end

        // R5: out-of-range channel changes nothing
        meas("R6 set", 3, 16'(base_m[3] + 50));
        meas("R5 bad channel", 6, 16'hFFFF);
        meas("R5 bad channel", 7, 16'h0000);

        // R7: latched mode
        lat_a_m = 1'b1; lat_w_m = 1'b1;
        wr(22, 16'h0003);
        wr(23, 16'h03FF); exp_a = '0;
        wr(24, 16'h03FF); exp_w = '0;
        @(negedge clk);
        chk("R7 clear all alarm", {6'd0, alarm_flags}, 16'd0);
        chk("R7 clear all warn",  {6'd0, warn_flags},  16'd0);
        for (int c = 0; c < 5; c++) begin
            sweep("R7 latched up", c, 1'b0);
            sweep("R7 latched down", c, 1'b1);
        end
        // R7: selective clear of one alarm bit and one warning bit
        wr(23, 16'h0004); exp_a &= ~10'h004;
        wr(24, 16'h0200); exp_w &= ~10'h200;
        chk("R7 partial clear alarm", {6'd0, alarm_flags}, {6'd0, exp_a});
        chk("R7 partial clear warn",  {6'd0, warn_flags},  {6'd0, exp_w});

        // R8: disable edge with latched flags on every channel
        for (int c = 0; c < 5; c++) meas("R8 prep high", c, 16'(base_m[c] + 60));
        @(negedge clk);
        tx_disable = 1'b1;
        exp_a &= ~10'b0011110000; exp_w &= ~10'b0011110000;
        @(negedge clk);
        chk("R8 edge clear alarm", {6'd0, alarm_flags}, {6'd0, exp_a});
        chk("R8 edge clear warn",  {6'd0, warn_flags},  {6'd0, exp_w});
        meas("R8 set under held disable", 2, 16'(base_m[2] + 60));
        repeat (3) @(negedge clk);
        chk("R8 held level keeps alarm", {6'd0, alarm_flags}, {6'd0, exp_a});
        chk("R8 held level keeps warn",  {6'd0, warn_flags},  {6'd0, exp_w});
        tx_disable = 1'b0;
        repeat (2) @(negedge clk);

        // R8: transparent flags survive the edge
        lat_a_m = 1'b0; lat_w_m = 1'b0;
        wr(22, 16'h0000);
        meas("R8 transparent prep", 3, 16'(base_m[3] + 60));
        tx_disable = 1'b1;
        @(negedge clk);
        chk("R8 transparent kept alarm", {6'd0, alarm_flags}, {6'd0, exp_a});
        chk("R8 transparent kept warn",  {6'd0, warn_flags},  {6'd0, exp_w});
        tx_disable = 1'b0;

        // R9: masks gate the fault
        aen_m = '0; wen_m = '0;
        wr(20, 16'd0); wr(21, 16'd0);
        @(negedge clk);
        chk("R9 masked fault", {15'd0, tx_fault}, 16'd0);
        aen_m = 10'b0001000000;
        wr(20, {6'd0, aen_m});
        @(negedge clk);
        chk("R9 single enable", {15'd0, tx_fault}, {15'd0, exp_fault()});
        meas("R9 drop", 3, 16'(base_m[3]));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule